// File: doc/BRIEF.md
# Dual-Role Controller Interrupt Status Register

This block holds the core interrupt status word of a controller that can act as either host or device. The status bits behave differently. Two bits are sticky: they latch on an event and software clears them by writing one. Two bits follow live levels from the receive FIFO and from the transmit FIFO and request queue. One bit is the OR of a separate event register. One bit reports the result of a handshake with a control register that sets and releases a global IN NAK condition. Bit 0 reports the active role. A per-bit mask picks which status bits drive the single interrupt line.

Software reaches the block over a simple single-cycle register bus: select, write enable, address and data in, with read data returned in the same cycle. Two registers belong to only one role. The scratch configuration register at address 4 is host-only. The NAK control register at address 5 is device-only. An access to either register while the other role is active raises the mismatch bit. The access still completes on the bus, but a write is dropped and a read returns zero.

The NAK handshake is a three-state machine. IDLE moves to WAIT when software writes the set strobe. WAIT moves to ACTIVE when the core reports that it is between IN transfers, which is the point where it samples the request. A write of the release strobe sends IDLE, WAIT or ACTIVE back to IDLE. Any other input leaves the state where it is.

Top module: `irq_status_core`

## Requirements
- R1: After reset the status word, mask, event register, configuration, scratch register and NAK state are all zero, and the interrupt line is low.
- R2: Status bit 0 equals the role input (0 = device, 1 = host) in every cycle.
- R3: Status bit 1 sets after any selected access, read or write, to address 4 while in device mode, or to address 5 while in host mode. Writing a word with bit 1 set to address 0 clears it. A mismatch in the same cycle as the clear wins.
- R4: A wrong-role access changes no state other than bit 1. The write is dropped and the read data is zero.
- R5: The event register at address 2 sets bit i on event pulse i. Writing a one to bit i clears it, and a pulse in the same cycle wins. Status bit 2 is the OR of all event register bits.
- R6: Status bit 3 sets on a frame-start pulse. Writing a word with bit 3 set to address 0 clears it. A pulse in the same cycle as the clear keeps it set.
- R7: Status bit 4 is high exactly while the receive packet count is non-zero.
- R8: Status bit 5 is high only in host mode, when the request queue has free room, and when the transmit FIFO meets the empty level set by configuration bit 0 at address 3. That bit is 0 for at least half of the words free and 1 for all words free. Otherwise bit 5 is low.
- R9: A write of data bit 0 to address 5 moves IDLE to WAIT. WAIT moves to ACTIVE on a cycle with the idle input high. A write of data bit 1 to address 5 returns any state to IDLE and wins over a set in the same word. Status bit 6 is high in ACTIVE while in device mode.
- R10: The interrupt line is the OR of the status bits ANDed with the 7-bit mask, which is read and written at address 1.
- R11: Writing zero to a write-one-clear bit has no effect. Writes to status bits 0, 2, 4, 5 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| host_mode | input | 1 | Active role, 1 = host |
| rx_pkt_cnt | input | 4 | Packets waiting in receive FIFO |
| txf_free | input | 5 | Free words in transmit FIFO |
| txq_free | input | 3 | Free entries in transmit request queue |
| evt_pulse | input | 4 | Secondary protocol event pulses |
| sof_evt | input | 1 | Frame-start pulse |
| in_idle | input | 1 | Core is between IN transfers (NAK sample point) |
| sts_o | output | 7 | Status word |
| irq_o | output | 1 | Interrupt line |

## Verification
The directed patterns isolate each clearing style. A sticky bit gets a lone pulse, a clear with data zero, and a pulse that lands in the same cycle as its clear. The level bits are swept across the empty-level threshold in both configurations and in both roles. The NAK machine is driven through each transition, including a set while idle is low, a release issued from the wrong role, and a set and release written in the same word. A long random phase mixes role changes, bus traffic to every address and event pulses. Against a reference model it shows up ordering faults between set and clear, and state that leaks through wrong-role accesses.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
    localparam int ADDR_W = 3;
    localparam int STS_W  = 7;

    localparam int B_ROLE = 0;
    localparam int B_MISM = 1;
    localparam int B_AUX  = 2;
    localparam int B_SOF  = 3;
    localparam int B_RXNE = 4;
    localparam int B_TXE  = 5;
    localparam int B_NAK  = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 3'd0,
        A_MASK   = 3'd1,
        A_EVT    = 3'd2,
        A_CFG    = 3'd3,
        A_HOST   = 3'd4,
        A_DEV    = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic sts;
        logic mask;
        logic evt;
        logic cfg;
        logic host;
        logic dev;
    } wr_sel_t;

    typedef enum logic [1:0] {
        NAK_IDLE   = 2'd0,
        NAK_WAIT   = 2'd1,
        NAK_ACTIVE = 2'd2
    } nak_state_e;
endpackage

// File: rtl/irqstat_decode.sv
module irqstat_decode
    import irqstat_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              host_mode,
    output logic              wrong_role,
    output wr_sel_t           wsel
);
    always_comb begin
        wrong_role = bus_sel &&
                     (((bus_addr == A_HOST) && !host_mode) ||
                      ((bus_addr == A_DEV)  &&  host_mode));
        wsel = '0;
        if (bus_sel && bus_wr && !wrong_role) begin
            case (reg_addr_e'(bus_addr))
                A_STATUS: wsel.sts  = 1'b1;
                A_MASK:   wsel.mask = 1'b1;
                A_EVT:    wsel.evt  = 1'b1;
                A_CFG:    wsel.cfg  = 1'b1;
                A_HOST:   wsel.host = 1'b1;
                A_DEV:    wsel.dev  = 1'b1;
                default:  wsel      = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqstat_evtreg.sv
module irqstat_evtreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_in,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_in[i])
                q[i] <= 1'b1;
            else if (clr_we && clr_data[i])
                q[i] <= 1'b0;
        end
    end

    AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_in) |=> ((q & $past(set_in)) == $past(set_in))); // R5
endmodule

// File: rtl/irqstat_txempty.sv
module irqstat_txempty #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int QW    = 3
) (
    input  logic          host_mode,
    input  logic          full_sel,
    input  logic [CW-1:0] free_words,
    input  logic [QW-1:0] q_free,
    output logic          tx_ready
);
    localparam int HALF = (DEPTH + 1) / 2;
    logic level_ok;

    always_comb begin
        if (full_sel)
            level_ok = (free_words == CW'(DEPTH));
        else
            level_ok = (free_words >= CW'(HALF));
        tx_ready = host_mode && (q_free != '0) && level_ok;
    end
endmodule

// File: rtl/irqstat_nak_fsm.sv
module irqstat_nak_fsm
    import irqstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic sample_ok,
    output logic nak_active
);
    nak_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= NAK_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (clr_req) begin
            state_nx = NAK_IDLE;
        end else begin
            unique case (state)
                NAK_IDLE:   if (set_req)   state_nx = NAK_WAIT;
                NAK_WAIT:   if (sample_ok) state_nx = NAK_ACTIVE;
                NAK_ACTIVE: state_nx = NAK_ACTIVE;
                default:    state_nx = NAK_IDLE;
            endcase
        end
    end

    always_comb begin
        nak_active = (state == NAK_ACTIVE);
    end

    AST_NAK_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NAK_IDLE) |=> (state != NAK_ACTIVE)); // R9
    AST_NAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (state == NAK_IDLE)); // R9
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irqstat_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int EVT_W     = 4,
    parameter int RXC_W     = 4,
    parameter int TXF_DEPTH = 16,
    parameter int TXF_CW    = $clog2(TXF_DEPTH + 1),
    parameter int TXQ_W     = 3,
    parameter int SCR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              host_mode,
    input  logic [RXC_W-1:0]  rx_pkt_cnt,
    input  logic [TXF_CW-1:0] txf_free,
    input  logic [TXQ_W-1:0]  txq_free,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              sof_evt,
    input  logic              in_idle,
    output logic [STS_W-1:0]  sts_o,
    output logic              irq_o
);
    wr_sel_t            wsel;
    logic               wrong_role;
    logic               mism_q, sof_q, cfg_full_q;
    logic [STS_W-1:0]   mask_q;
    logic [SCR_W-1:0]   scr_q;
    logic [EVT_W-1:0]   evt_q;
    logic               tx_ready, nak_active;

    irqstat_decode u_dec (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .host_mode  (host_mode),
        .wrong_role (wrong_role),
        .wsel       (wsel)
    );

    irqstat_evtreg #(.W(EVT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_in   (evt_pulse),
        .clr_we   (wsel.evt),
        .clr_data (bus_wdata[EVT_W-1:0]),
        .q        (evt_q)
    );

    irqstat_txempty #(.DEPTH(TXF_DEPTH), .CW(TXF_CW), .QW(TXQ_W)) u_txe (
        .host_mode  (host_mode),
        .full_sel   (cfg_full_q),
        .free_words (txf_free),
        .q_free     (txq_free),
        .tx_ready   (tx_ready)
    );

    irqstat_nak_fsm u_nak (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (wsel.dev && bus_wdata[0]),
        .clr_req    (wsel.dev && bus_wdata[1]),
        .sample_ok  (in_idle),
        .nak_active (nak_active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q     <= 1'b0;
            sof_q      <= 1'b0;
            mask_q     <= '0;
            cfg_full_q <= 1'b0;
            scr_q      <= '0;
        end else begin
            if (wrong_role)
                mism_q <= 1'b1;
            else if (wsel.sts && bus_wdata[B_MISM])
                mism_q <= 1'b0;
            if (sof_evt)
                sof_q <= 1'b1;
            else if (wsel.sts && bus_wdata[B_SOF])
                sof_q <= 1'b0;
            if (wsel.mask)
                mask_q <= bus_wdata[STS_W-1:0];
            if (wsel.cfg)
                cfg_full_q <= bus_wdata[0];
            if (wsel.host)
                scr_q <= bus_wdata[SCR_W-1:0];
        end
    end

    always_comb begin
        sts_o          = '0;
        sts_o[B_ROLE]  = host_mode;
        sts_o[B_MISM]  = mism_q;
        sts_o[B_AUX]   = |evt_q;
        sts_o[B_SOF]   = sof_q;
        sts_o[B_RXNE]  = (rx_pkt_cnt != '0);
        sts_o[B_TXE]   = tx_ready;
        sts_o[B_NAK]   = nak_active && !host_mode;
        irq_o          = |(sts_o & mask_q);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !wrong_role) begin
            case (reg_addr_e'(bus_addr))
                A_STATUS: bus_rdata = DATA_W'(sts_o);
                A_MASK:   bus_rdata = DATA_W'(mask_q);
                A_EVT:    bus_rdata = DATA_W'(evt_q);
                A_CFG:    bus_rdata = DATA_W'(cfg_full_q);
                A_HOST:   bus_rdata = DATA_W'(scr_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && wrong_role) |=> sts_o[B_MISM]); // R3
    AST_WRONG_ROLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && wrong_role) |=> $stable(scr_q)); // R4
    AST_SOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sof_evt |=> sts_o[B_SOF]); // R6
    AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R10
endmodule

// File: tb/irq_status_core_tb_top.sv
module irq_status_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_mode = 1'b0;
    logic [3:0]  rx_pkt_cnt = '0;
    logic [4:0]  txf_free = '0;
    logic [2:0]  txq_free = '0;
    logic [3:0]  evt_pulse = '0;
    logic        sof_evt = 1'b0, in_idle = 1'b0;
    logic [6:0]  sts_o;
    logic        irq_o;

    int checks = 0, failures = 0;
    logic [31:0] rv;

    // reference model state
    int m_mism, m_sof, m_cfg, m_nak;
    int m_mask, m_scr;
    int m_evt[4];

    always #10 clk = ~clk;

    irq_status_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_mode(host_mode), .rx_pkt_cnt(rx_pkt_cnt), .txf_free(txf_free),
        .txq_free(txq_free), .evt_pulse(evt_pulse), .sof_evt(sof_evt),
        .in_idle(in_idle), .sts_o(sts_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_wrong();
        return bus_sel && ((bus_addr == 3'd4 && !host_mode) || (bus_addr == 3'd5 && host_mode));
    endfunction

    function automatic logic [6:0] exp_sts();
        logic [6:0] s;
        int any;
        any = 0;
        for (int i = 0; i < 4; i++) if (m_evt[i] != 0) any = 1;
        s[0] = host_mode;
        s[1] = (m_mism != 0);
        s[2] = (any != 0);
        s[3] = (m_sof != 0);
        s[4] = (rx_pkt_cnt != 0);
        s[5] = host_mode && (txq_free != 0) &&
               ((m_cfg != 0) ? (txf_free == 16) : (int'(txf_free) * 2 >= 16));
        s[6] = (m_nak == 2) && !host_mode;
        return s;
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v;
        v = '0;
        if (bus_sel && !is_wrong()) begin
            case (bus_addr)
                3'd0: v = {25'd0, exp_sts()};
                3'd1: v = 32'(m_mask);
                3'd2: for (int i = 0; i < 4; i++) v[i] = (m_evt[i] != 0);
                3'd3: v = 32'(m_cfg);
                3'd4: v = 32'(m_scr);
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    function automatic string sts_tag(input logic [6:0] d);
        if (d[0]) return "R2";
        if (d[1]) return "R3";
        if (d[2]) return "R5";
        if (d[3]) return "R6";
        if (d[4]) return "R7";
        if (d[5]) return "R8";
        return "R9";
    endfunction

    function automatic string rd_tag();
        if (is_wrong()) return "R4";
        case (bus_addr)
            3'd0: return "R11";
            3'd1: return "R10";
            3'd2: return "R5";
            3'd3: return "R8";
            3'd4: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic model_step();
        bit wrong, w;
        if (!rst_n) begin
            m_mism = 0; m_sof = 0; m_cfg = 0; m_nak = 0; m_mask = 0; m_scr = 0;
            for (int i = 0; i < 4; i++) m_evt[i] = 0;
            return;
        end
        wrong = is_wrong();
        w = bus_sel && bus_wr && !wrong;
        if (wrong) m_mism = 1;
        else if (w && bus_addr == 0 && bus_wdata[1]) m_mism = 0;
        if (sof_evt) m_sof = 1;
        else if (w && bus_addr == 0 && bus_wdata[3]) m_sof = 0;
        for (int i = 0; i < 4; i++) begin
            if (evt_pulse[i]) m_evt[i] = 1;
            else if (w && bus_addr == 2 && bus_wdata[i]) m_evt[i] = 0;
        end
        if (w && bus_addr == 1) m_mask = int'(bus_wdata[6:0]);
        if (w && bus_addr == 3) m_cfg = int'(bus_wdata[0]);
        if (w && bus_addr == 4) m_scr = int'(bus_wdata[7:0]);
        if (w && bus_addr == 5 && bus_wdata[1]) m_nak = 0;
        else if (m_nak == 1 && in_idle) m_nak = 2;
        else if (m_nak == 0 && w && bus_addr == 5 && bus_wdata[0]) m_nak = 1;
    endtask

    task automatic cyc();
        logic [6:0] es;
        @(posedge clk);
        model_step();
        #5;
        es = exp_sts();
        if (sts_o !== es) chk(sts_tag(sts_o ^ es), 32'(sts_o), 32'(es));
        else checks++;
        chk("R10", 32'(irq_o), 32'(|(es & 7'(m_mask))));
        chk(rd_tag(), bus_rdata, exp_rdata());
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        cyc();
        bus_sel = 0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_step();
        repeat (3) @(negedge clk);
        cyc();
        chk("R1", 32'(sts_o), 32'h0);
        chk("R1", 32'(irq_o), 32'h0);
        rst_n = 1;
        cyc();
        rd(3'd1, rv); chk("R1", rv, 32'h0);

        // R2 role bit
        host_mode = 1; cyc(); chk("R2", 32'(sts_o[0]), 1);

        // R8 transmit empty level
        txq_free = 1; txf_free = 8; cyc(); chk("R8", 32'(sts_o[5]), 1);
        txf_free = 7; cyc(); chk("R8", 32'(sts_o[5]), 0);
        wr(3'd3, 1); txf_free = 15; cyc(); chk("R8", 32'(sts_o[5]), 0);
        txf_free = 16; cyc(); chk("R8", 32'(sts_o[5]), 1);
        txq_free = 0; cyc(); chk("R8", 32'(sts_o[5]), 0);
        txq_free = 2; host_mode = 0; cyc(); chk("R8", 32'(sts_o[5]), 0);

        // R7 receive level
        rx_pkt_cnt = 3; cyc(); chk("R7", 32'(sts_o[4]), 1);
        rx_pkt_cnt = 0; cyc(); chk("R7", 32'(sts_o[4]), 0);

        // R6 / R11 frame start
        sof_evt = 1; cyc(); sof_evt = 0; chk("R6", 32'(sts_o[3]), 1);
        wr(3'd0, 0); chk("R11", 32'(sts_o[3]), 1);
        wr(3'd0, 32'h75); chk("R11", 32'(sts_o[3]), 1);
        wr(3'd0, 8); chk("R6", 32'(sts_o[3]), 0);
        sof_evt = 1; wr(3'd0, 8); sof_evt = 0; chk("R6", 32'(sts_o[3]), 1);
        wr(3'd0, 8);

        // R3 / R4 wrong-role accesses
        host_mode = 1; wr(3'd4, 32'h5A); rd(3'd4, rv); chk("R4", rv, 32'h5A);
        chk("R3", 32'(sts_o[1]), 0);
        host_mode = 0; wr(3'd4, 32'hAB); chk("R3", 32'(sts_o[1]), 1);
        rd(3'd4, rv); chk("R4", rv, 32'h0);
        host_mode = 1; rd(3'd4, rv); chk("R4", rv, 32'h5A);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 2; cyc();
        bus_sel = 0; bus_wr = 0; chk("R3", 32'(sts_o[1]), 0);
        rd(3'd5, rv); chk("R3", 32'(sts_o[1]), 1);
        wr(3'd0, 2); chk("R3", 32'(sts_o[1]), 0);

        // R9 NAK handshake
        host_mode = 0; in_idle = 0;
        wr(3'd5, 1); chk("R9", 32'(sts_o[6]), 0);
        cyc(); chk("R9", 32'(sts_o[6]), 0);
        in_idle = 1; cyc(); in_idle = 0; chk("R9", 32'(sts_o[6]), 1);
        host_mode = 1; cyc(); chk("R9", 32'(sts_o[6]), 0);
        wr(3'd5, 2); host_mode = 0; cyc(); chk("R4", 32'(sts_o[6]), 1);
        wr(3'd5, 2); chk("R9", 32'(sts_o[6]), 0);
        in_idle = 1; wr(3'd5, 3); cyc(); cyc(); in_idle = 0;
        chk("R9", 32'(sts_o[6]), 0);
        wr(3'd0, 2);

        // R5 / R11 event register summary
        evt_pulse = 4'b0100; cyc(); evt_pulse = 0; chk("R5", 32'(sts_o[2]), 1);
        wr(3'd0, 4); chk("R11", 32'(sts_o[2]), 1);
        evt_pulse = 4'b0100; wr(3'd2, 4); evt_pulse = 0; chk("R5", 32'(sts_o[2]), 1);
        wr(3'd2, 4); chk("R5", 32'(sts_o[2]), 0);

        // R10 mask
        wr(3'd1, 32'h08); sof_evt = 1; cyc(); sof_evt = 0; chk("R10", 32'(irq_o), 1);
        wr(3'd1, 0); chk("R10", 32'(irq_o), 0);
        wr(3'd0, 8);

        // random phase compared against the model every cycle
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 15) == 0) host_mode = ~host_mode;
            rx_pkt_cnt = 4'($urandom_range(0, 2));
            txf_free   = 5'($urandom_range(0, 16));
            txq_free   = 3'($urandom_range(0, 2));
            evt_pulse  = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'd0;
            sof_evt    = ($urandom_range(0, 6) == 0);
            in_idle    = $urandom_range(0, 1) != 0;
            bus_sel    = $urandom_range(0, 2) == 0;
            bus_wr     = $urandom_range(0, 1) != 0;
            bus_addr   = 3'($urandom_range(0, 7));
            bus_wdata  = $urandom;
            cyc();
        end
        bus_sel = 0; bus_wr = 0;
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule